// File: doc/BRIEF.md
# Infrared Carrier Period and Duty Meter

This block sits on a raw, still-modulated infrared receiver line and measures the carrier that rides on it. The line is first brought into the clock domain and cleaned of short glitches. The time from one rising edge of the carrier to the next is then counted in ticks of a 500 ns timebase, and so is the time the carrier stays high within that cycle. The timebase is made from the system clock by a prescaler of `TICK_DIV` clock cycles. With a count `P`, software works out the carrier frequency as 2,000,000 / `P` Hz and the duty as high count × 100 / `P` percent.

The two results are held in two 8-bit registers, which are read through a small registered read port. The period register has a valid flag in its top bit and the count in the lower seven bits. Reading the period register clears the flag. A result that would mislead software never raises the flag: a count of zero, or a period too long for seven bits. Measurement runs only while the detection enable input is high. While it is low, both registers keep their contents.

Top module: `ir_carrier_meter`

## Requirements
- R1: After reset, both the period register (select 0) and the high-time register (select 1) read back as 0x00.
- R2: For successive filtered rising edges N clock cycles apart, the period field (bits 6:0 of select 0) equals floor(N / TICK_DIV).
- R3: The high-time register (select 1) holds floor(H / TICK_DIV) in bits 6:0, where H is the number of clock cycles from the rising edge to the falling edge of that carrier cycle. Bit 7 always reads 0.
- R4: When a measurement completes with a period count from 1 to 127, bit 7 of the period register (the valid flag) is set.
- R5: A period count of zero is stored as 0 with the valid flag clear.
- R6: If a period lasts 128 ticks or more, the period field saturates at 127 and the valid flag is clear. The high-time field also saturates at 127.
- R7: A read of the period register clears its valid flag from the next cycle on. A measurement that completes in the same cycle as the read takes precedence over the clear.
- R8: While the detection enable is low, neither register changes. After the enable rises, the first rising edge only starts a measurement and does not complete one.
- R9: Level changes on the raw input that last fewer than FILT_LEN clock cycles are ignored. Accepted edges pass through a two-flop synchroniser, which delays rising and falling edges by the same amount.
- R10: A read request with select 0 (period) or select 1 (high time) presents that register on the read data output in the cycle after the request. Between reads, the output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_raw | input | 1 | Asynchronous raw (undemodulated) infrared input |
| det_en | input | 1 | Carrier detection enable |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | Register select: 0 period, 1 high time |
| rd_data | output | 8 | Registered read data |

## Verification
The bench sweeps carrier periods across the whole tick range, including periods shorter than one tick. A design that stored a zero count as valid, or that was off by one tick in its prescaler phase, would report a wrong count or a wrong flag across the sweep. A period of more than 127 ticks checks that the count saturates instead of wrapping, which would show up as a small plausible frequency. Other tests inject a one-cycle glitch inside the high phase and switch the enable off around a new waveform. A missing filter would measure the glitch as a short cycle. A meter that ignored the enable would overwrite the held result. A second read after the first checks that the flag was cleared, and the select 1 reads check that the high-time register keeps bit 7 at zero.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int REG_W = 8;
  localparam int CNT_W = REG_W - 1;

  typedef struct packed {
    logic             ok;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] hi;
  } meas_t;

  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_HIGH   = 1'b1
  } sel_e;
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic          s1, s2, filt, filt_d;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
      fcnt   <= '0;
    end else begin
      s1     <= raw_i;
      s2     <= s1;
      filt_d <= filt;
      if (s2 == filt) begin
        fcnt <= '0;
      end else if (fcnt == FW'(FILT_LEN - 1)) begin
        filt <= s2;
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign rise_o = filt & ~filt_d;
  assign fall_o = ~filt & filt_d;

  // R9
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s2 == filt) |=> $stable(filt));
endmodule

// File: rtl/cm_meter.sv
module cm_meter
  import cm_pkg::*;
#(
  parameter int TICK_DIV = 48
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en_i,
  input  logic  rise_i,
  input  logic  fall_i,
  output logic  commit_o,
  output meas_t meas_o
);
  localparam int PRE_W = $clog2(TICK_DIV);
  localparam logic [CNT_W:0] SAT = {1'b1, {CNT_W{1'b0}}};

  logic [PRE_W-1:0] pre;
  logic [CNT_W:0]   cnt, hi_cap;
  logic             armed;

  function automatic logic [CNT_W-1:0] clip(input logic [CNT_W:0] v);
    return v[CNT_W] ? {CNT_W{1'b1}} : v[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= PRE_W'(1);
      cnt      <= '0;
      hi_cap   <= '0;
      armed    <= 1'b0;
      commit_o <= 1'b0;
      meas_o   <= '0;
    end else if (!en_i) begin
      pre      <= PRE_W'(1);
      cnt      <= '0;
      hi_cap   <= '0;
      armed    <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (rise_i) begin
        pre   <= PRE_W'(1);
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) begin
          commit_o    <= 1'b1;
          meas_o.per  <= clip(cnt);
          meas_o.hi   <= clip(hi_cap);
          meas_o.ok   <= (cnt != '0) && !cnt[CNT_W];
        end
      end else if (pre == PRE_W'(TICK_DIV - 1)) begin
        pre <= '0;
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (fall_i) hi_cap <= cnt;
    end
  end

  // R8
  no_commit_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !commit_o);
  // R3
  hi_le_per_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_o && meas_o.ok) |-> (meas_o.hi <= meas_o.per));
  // R6
  sat_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_o && meas_o.per == {CNT_W{1'b1}} && meas_o.ok) |-> $past(cnt) != SAT);
endmodule

// File: rtl/cm_regs.sv
module cm_regs
  import cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  meas_t            meas_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] per_q, hi_q;
  logic             vld_q;
  sel_e             sel;

  assign sel = sel_e'(rd_sel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q     <= '0;
      hi_q      <= '0;
      vld_q     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (commit_i) begin
        per_q <= meas_i.per;
        hi_q  <= meas_i.hi;
        vld_q <= meas_i.ok;
      end else if (rd_en_i && sel == SEL_PERIOD) begin
        vld_q <= 1'b0;
      end
      if (rd_en_i) begin
        rd_data_o <= (sel == SEL_HIGH) ? {1'b0, hi_q} : {vld_q, per_q};
      end
    end
  end

  // R5
  valid_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (per_q != '0));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel == SEL_PERIOD && !commit_i) |=> !vld_q);
  // R3
  hi_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel == SEL_HIGH) |=> !rd_data_o[REG_W-1]);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter #(
  parameter int TICK_DIV = 48,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ir_raw,
  input  logic       det_en,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data
);
  logic          rise, fall, commit;
  cm_pkg::meas_t meas;

  cm_sync #(.FILT_LEN(FILT_LEN)) u_sync (
    .clk(clk), .rst(rst), .raw_i(ir_raw), .rise_o(rise), .fall_o(fall)
  );

  cm_meter #(.TICK_DIV(TICK_DIV)) u_meter (
    .clk(clk), .rst(rst), .en_i(det_en), .rise_i(rise), .fall_i(fall),
    .commit_o(commit), .meas_o(meas)
  );

  cm_regs u_regs (
    .clk(clk), .rst(rst), .commit_i(commit), .meas_i(meas),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );
endmodule

// File: tb/sim_ir_carrier_meter.sv
module sim_ir_carrier_meter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int FL = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ir_raw = 1'b0;
  logic       det_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;

  int vectors = 0;
  int miss = 0;
  bit done = 0;

  ir_carrier_meter #(.TICK_DIV(DIV), .FILT_LEN(FL)) u0 (
    .clk(clk), .rst(rst), .ir_raw(ir_raw), .det_en(det_en),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_en  = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_en  = 1'b0;
    v = rd_data;
  endtask

  task automatic wave(input int p, input int h, input int n);
    for (int i = 0; i < n; i++) begin
      ir_raw = 1'b1;
      repeat (h) @(negedge clk);
      ir_raw = 1'b0;
      repeat (p - h) @(negedge clk);
    end
    ir_raw = 1'b1;
    repeat (h) @(negedge clk);
    ir_raw = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [7:0] per_exp(input int p);
    int c = p / DIV;
    if (c > 127) return 8'h7F;
    return {c != 0, 7'(c)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miss++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, v); chk("R1 period reset", v, 8'h00);
    rd(1'b1, v); chk("R1 high reset", v, 8'h00);

    det_en = 1'b1;
    // R2 R3 R4 R5 R10 sweep
    for (int p = 4; p <= 130; p++) begin
      int h = 2 + (p * 7) % (p - 3);
      wave(p, h, 2);
      rd(1'b0, v); chk($sformatf("R2/R4/R5 period p=%0d", p), v, per_exp(p));
      rd(1'b1, v); chk($sformatf("R3/R10 high p=%0d h=%0d", p, h), v, {1'b0, 7'(h / DIV)});
      rd(1'b0, v); chk($sformatf("R7 reread p=%0d", p), v, {1'b0, per_exp(p)[6:0]});
    end

    // R6 overflow
    wave(1100, 550, 1);
    rd(1'b0, v); chk("R6 saturate", v, 8'h7F);
    rd(1'b1, v); chk("R6 high", v, 8'd68);

    // R9 glitch inside high phase
    for (int i = 0; i < 2; i++) begin
      ir_raw = 1'b1; repeat (8) @(negedge clk);
      ir_raw = 1'b0; @(negedge clk);
      ir_raw = 1'b1; repeat (11) @(negedge clk);
      ir_raw = 1'b0; repeat (20) @(negedge clk);
    end
    ir_raw = 1'b1; repeat (20) @(negedge clk);
    ir_raw = 1'b0; repeat (12) @(negedge clk);
    rd(1'b0, v); chk("R9 glitch period", v, 8'h85);
    rd(1'b1, v); chk("R9 glitch high", v, 8'h02);

    // R8 enable gating
    wave(40, 20, 2);
    rd(1'b0, v); chk("R8 base", v, 8'h85);
    det_en = 1'b0;
    wave(24, 12, 2);
    rd(1'b0, v); chk("R8 held period", v, 8'h05);
    rd(1'b1, v); chk("R8 held high", v, 8'h02);
    det_en = 1'b1;
    ir_raw = 1'b1; repeat (12) @(negedge clk);
    ir_raw = 1'b0; repeat (30) @(negedge clk);
    rd(1'b0, v); chk("R8 first edge arms only", v, 8'h05);
    wave(24, 12, 2);
    rd(1'b0, v); chk("R8 resumed period", v, 8'h83);
    rd(1'b1, v); chk("R8 resumed high", v, 8'h01);

    finish_run();
  end
endmodule